// File: doc/BRIEF.md
# Closed-Loop PWM Trim Regulator

This block drives one converter's trim input. It produces a PWM signal whose low-pass-filtered average becomes the trim voltage. It then moves the duty count one step at a time until the filtered ADC reading of the converter's output matches a selected target. There are four targets: nominal, alternate, margin-high and margin-low. Mode pins choose among them.

Converters do not all trim in the same direction, so the block learns the direction when it starts. It applies a small duty nudge and checks which way the measured voltage moves. If the reading does not move, the nudge is doubled and tried again, up to a fixed number of attempts. After the last attempt the block raises a failure flag.

Some converters trim by shifting their internal reference. For these, the block first charges the filter capacitor by running at full duty, with the converter still disabled. After a set number of samples it enables the converter and servos the duty downward. In this case the trim direction is known, so no learning step is run. One block serves one channel. Several channels are handled by placing several instances.

Top module: `trim_regulator`

## Requirements
- R1: The PWM period is 1024 counter steps, and each step lasts PRE_DIV clocks. Within a period the output is high for exactly `duty` steps, the steps where the counter is below the latched duty. The latched duty is taken from `duty` only at the period boundary. A duty of 0 gives a constant low output.
- R2: Target selection uses a fixed priority, highest first:
  - `mfg_mode` and `mrg_hi` both high select `tgt_hi`.
  - Otherwise, `mfg_mode` and `mrg_lo` both high select `tgt_lo`.
  - Otherwise, `alt_sel` and `dual_cfg` both high select `tgt_alt`.
  - In every other case `tgt_nom` is selected.
  - The margin pins have no effect while `mfg_mode` is low.
- R3: Learning (non-reference type) works as follows:
  - After `run` rises, the first sample is kept as a baseline.
  - The duty then moves by the nudge amount, starting at NUDGE0. It moves up if the duty is below 512 and down otherwise, saturating at the range ends.
  - On the next sample, a change larger than `deadband` sets `pol_up`. `pol_up` is 1 when the reading moved in the same direction as the duty, and 0 when it moved the opposite way.
  - The block then enters servo mode and keeps the nudged duty.
- R4: If a nudge produces a change no larger than `deadband`, the duty is restored and the nudge is doubled. After LRN_TRIES attempts without a change, `learn_fail` goes high and the duty returns to its pre-nudge value. Both stay that way until `run` falls.
- R5: In servo mode, each `smp_valid` pulse is followed by at most one step of ±1 in the duty. The step is taken only when target minus sample is outside ±`deadband`. When `pol_up`=1, a positive error increments the duty; when `pol_up`=0 the direction is inverted.
- R6: The duty saturates at 0 and 1023 and never wraps.
- R7: On each servo sample, `settled` goes high when target minus sample lies within ±`deadband`. It goes low on any sample that causes a step.
- R8: With `ref_type` high, `run` rising sets the duty to 1023 and holds `conv_en` low for PRE_SAMPLES samples. After that, `conv_en` rises, `pol_up` becomes 1, and servo mode starts with no learning step.
- R9: While `run` is low, the following hold: the duty follows `init_duty`, `conv_en` is low, `settled` is low and `learn_fail` is low.
- R10: A synchronous reset clears `conv_en`, `settled`, `learn_fail`, `pol_up` and `pwm_out`, and loads the duty from `init_duty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start or keep regulating; low returns to idle |
| ref_type | input | 1 | 1 = reference-shifting converter (precharge path) |
| dual_cfg | input | 1 | Channel accepts the alternate set point |
| alt_sel | input | 1 | Request the alternate set point |
| mfg_mode | input | 1 | Enables the margin pins |
| mrg_hi | input | 1 | Margin high request |
| mrg_lo | input | 1 | Margin low request |
| tgt_nom | input | ADC_W | Nominal target reading |
| tgt_alt | input | ADC_W | Alternate target reading |
| tgt_hi | input | ADC_W | Margin-high target reading |
| tgt_lo | input | ADC_W | Margin-low target reading |
| deadband | input | ADC_W | Error tolerance and learn threshold |
| init_duty | input | DUTY_W | Duty used at idle and at start |
| smp_valid | input | 1 | One-cycle pulse for a new filtered sample |
| smp_data | input | ADC_W | Filtered ADC reading |
| pwm_out | output | 1 | Trim PWM |
| conv_en | output | 1 | Converter enable |
| duty | output | DUTY_W | Current duty count |
| settled | output | 1 | Error within deadband |
| learn_fail | output | 1 | Polarity could not be learned |
| pol_up | output | 1 | Learned direction: 1 = more duty raises voltage |

## Verification
The bench uses plant models of both polarities, so it can catch a polarity learned backwards. A design that inverted the direction would run the duty off to a rail instead of settling at the computed count. Unreachable targets drive the duty into both rails. A design that wraps instead of saturating would jump from 1023 to 0 and oscillate, and a design that saturates at the wrong end would fail these cases as well.

A flat plant exercises the retry-and-fail path. A design with the wrong retry count, or one that keeps the nudged duty, shows up at once. Other cases cover the margin pins while manufacturing mode is low, the hi-over-lo priority, and the precharge hold of the enable. Together these catch a wrong target priority and an early enable.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECHG,
    ST_BASE,
    ST_NUDGE,
    ST_SERVO,
    ST_FAIL
  } trim_st_e;
endpackage

// File: rtl/trim_pwm_gen.sv
module trim_pwm_gen #(
  parameter int DUTY_W  = 10,
  parameter int PRE_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_out
);
  localparam logic [DUTY_W-1:0] CNT_LAST = '1;

  logic              step;
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] lat_q;
  logic              pwm_q;

  generate
    if (PRE_DIV <= 1) begin : g_nodiv
      assign step = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || pre_q == PW'(PRE_DIV - 1)) pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
      end
      assign step = (pre_q == PW'(PRE_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lat_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= (cnt_q < lat_q);
      if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) lat_q <= duty;
      end
    end
  end

  assign pwm_out = pwm_q;

  assert_pwm_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (lat_q == '0) |=> !pwm_q);
endmodule

// File: rtl/trim_target_sel.sv
module trim_target_sel #(
  parameter int ADC_W = 12
) (
  input  logic             mfg_mode,
  input  logic             mrg_hi,
  input  logic             mrg_lo,
  input  logic             alt_sel,
  input  logic             dual_cfg,
  input  logic [ADC_W-1:0] tgt_nom,
  input  logic [ADC_W-1:0] tgt_alt,
  input  logic [ADC_W-1:0] tgt_hi,
  input  logic [ADC_W-1:0] tgt_lo,
  output logic [ADC_W-1:0] target
);
  always_comb begin
    if (mfg_mode && mrg_hi)       target = tgt_hi;
    else if (mfg_mode && mrg_lo)  target = tgt_lo;
    else if (alt_sel && dual_cfg) target = tgt_alt;
    else                          target = tgt_nom;
  end
endmodule

// File: rtl/trim_servo.sv
module trim_servo
  import trim_pkg::*;
#(
  parameter int DUTY_W      = 10,
  parameter int ADC_W       = 12,
  parameter int NUDGE0      = 4,
  parameter int LRN_TRIES   = 3,
  parameter int PRE_SAMPLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ref_type,
  input  logic [DUTY_W-1:0] init_duty,
  input  logic [ADC_W-1:0]  target,
  input  logic [ADC_W-1:0]  deadband,
  input  logic              sample_valid,
  input  logic [ADC_W-1:0]  sample,
  output logic [DUTY_W-1:0] duty,
  output logic              conv_en,
  output logic              settled,
  output logic              learn_fail,
  output logic              pol_up
);
  localparam logic [DUTY_W-1:0] DMAX_V = '1;
  localparam logic [DUTY_W-1:0] HALF_V = DUTY_W'(2 ** (DUTY_W - 1));
  localparam logic [DUTY_W-1:0] ONE_V  = DUTY_W'(1);
  localparam int TRY_W = $clog2(LRN_TRIES + 1);
  localparam int PC_W  = $clog2(PRE_SAMPLES + 1);

  trim_st_e          st_q;
  logic [DUTY_W-1:0] duty_q, duty0_q, nudge_q;
  logic [ADC_W-1:0]  base_q;
  logic [TRY_W-1:0]  tries_q;
  logic [PC_W-1:0]   pcnt_q;
  logic              pol_q, dir_up_q, settled_q, fail_q, en_q;

  logic signed [ADC_W+1:0] err, diff, db_s;
  logic                    err_hi, err_lo, moved;

  function automatic logic [DUTY_W-1:0] move_duty(input logic [DUTY_W-1:0] d,
                                                  input logic [DUTY_W-1:0] amt,
                                                  input logic up);
    logic [DUTY_W:0] s;
    s = {1'b0, d} + {1'b0, amt};
    if (up) move_duty = s[DUTY_W] ? DMAX_V : s[DUTY_W-1:0];
    else    move_duty = (amt > d) ? '0 : d - amt;
  endfunction

  always_comb begin
    db_s   = $signed({2'b00, deadband});
    err    = $signed({2'b00, target}) - $signed({2'b00, sample});
    diff   = $signed({2'b00, sample}) - $signed({2'b00, base_q});
    err_hi = err > db_s;
    err_lo = err < -db_s;
    moved  = (diff > db_s) || (diff < -db_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      duty_q    <= init_duty;
      duty0_q   <= '0;
      nudge_q   <= '0;
      base_q    <= '0;
      tries_q   <= '0;
      pcnt_q    <= '0;
      pol_q     <= 1'b0;
      dir_up_q  <= 1'b0;
      settled_q <= 1'b0;
      fail_q    <= 1'b0;
      en_q      <= 1'b0;
    end else if (!run) begin
      st_q      <= ST_IDLE;
      duty_q    <= init_duty;
      settled_q <= 1'b0;
      fail_q    <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (ref_type) begin
            duty_q <= DMAX_V;
            pcnt_q <= '0;
            st_q   <= ST_PRECHG;
          end else begin
            en_q    <= 1'b1;
            nudge_q <= DUTY_W'(NUDGE0);
            tries_q <= '0;
            st_q    <= ST_BASE;
          end
        end
        ST_PRECHG: if (sample_valid) begin
          if (pcnt_q == PC_W'(PRE_SAMPLES - 1)) begin
            en_q  <= 1'b1;
            pol_q <= 1'b1;
            st_q  <= ST_SERVO;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        ST_BASE: if (sample_valid) begin
          base_q   <= sample;
          duty0_q  <= duty_q;
          dir_up_q <= duty_q < HALF_V;
          duty_q   <= move_duty(duty_q, nudge_q, duty_q < HALF_V);
          st_q     <= ST_NUDGE;
        end
        ST_NUDGE: if (sample_valid) begin
          if (moved) begin
            pol_q <= ((diff > 0) == dir_up_q);
            st_q  <= ST_SERVO;
          end else begin
            duty_q <= duty0_q;
            if (tries_q == TRY_W'(LRN_TRIES - 1)) begin
              fail_q <= 1'b1;
              st_q   <= ST_FAIL;
            end else begin
              tries_q <= tries_q + 1'b1;
              nudge_q <= nudge_q << 1;
              st_q    <= ST_BASE;
            end
          end
        end
        ST_SERVO: if (sample_valid) begin
          if (err_hi) begin
            duty_q    <= move_duty(duty_q, ONE_V, pol_q);
            settled_q <= 1'b0;
          end else if (err_lo) begin
            duty_q    <= move_duty(duty_q, ONE_V, !pol_q);
            settled_q <= 1'b0;
          end else begin
            settled_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign duty       = duty_q;
  assign conv_en    = en_q;
  assign settled    = settled_q;
  assign learn_fail = fail_q;
  assign pol_up     = pol_q;

  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SERVO && run && sample_valid) |=>
      (duty_q == $past(duty_q) ||
       {1'b0, duty_q} == {1'b0, $past(duty_q)} + 1'b1 ||
       {1'b0, duty_q} + 1'b1 == {1'b0, $past(duty_q)}));

  assert_settled_still_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SERVO && settled_q) |-> (duty_q == $past(duty_q)));

  assert_fail_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (fail_q && run) |=> fail_q);

  assert_prechg_off_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PRECHG) |-> !en_q);
endmodule

// File: rtl/trim_regulator.sv
module trim_regulator #(
  parameter int DUTY_W      = 10,
  parameter int ADC_W       = 12,
  parameter int PRE_DIV     = 10,
  parameter int NUDGE0      = 4,
  parameter int LRN_TRIES   = 3,
  parameter int PRE_SAMPLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ref_type,
  input  logic              dual_cfg,
  input  logic              alt_sel,
  input  logic              mfg_mode,
  input  logic              mrg_hi,
  input  logic              mrg_lo,
  input  logic [ADC_W-1:0]  tgt_nom,
  input  logic [ADC_W-1:0]  tgt_alt,
  input  logic [ADC_W-1:0]  tgt_hi,
  input  logic [ADC_W-1:0]  tgt_lo,
  input  logic [ADC_W-1:0]  deadband,
  input  logic [DUTY_W-1:0] init_duty,
  input  logic              smp_valid,
  input  logic [ADC_W-1:0]  smp_data,
  output logic              pwm_out,
  output logic              conv_en,
  output logic [DUTY_W-1:0] duty,
  output logic              settled,
  output logic              learn_fail,
  output logic              pol_up
);
  logic [ADC_W-1:0]  target;
  logic [DUTY_W-1:0] duty_w;

  trim_target_sel #(.ADC_W(ADC_W)) u_sel (
    .mfg_mode(mfg_mode), .mrg_hi(mrg_hi), .mrg_lo(mrg_lo),
    .alt_sel(alt_sel), .dual_cfg(dual_cfg),
    .tgt_nom(tgt_nom), .tgt_alt(tgt_alt), .tgt_hi(tgt_hi), .tgt_lo(tgt_lo),
    .target(target)
  );

  trim_servo #(
    .DUTY_W(DUTY_W), .ADC_W(ADC_W), .NUDGE0(NUDGE0),
    .LRN_TRIES(LRN_TRIES), .PRE_SAMPLES(PRE_SAMPLES)
  ) u_servo (
    .clk(clk), .rst(rst), .run(run), .ref_type(ref_type),
    .init_duty(init_duty), .target(target), .deadband(deadband),
    .sample_valid(smp_valid), .sample(smp_data),
    .duty(duty_w), .conv_en(conv_en), .settled(settled),
    .learn_fail(learn_fail), .pol_up(pol_up)
  );

  trim_pwm_gen #(.DUTY_W(DUTY_W), .PRE_DIV(PRE_DIV)) u_pwm (
    .clk(clk), .rst(rst), .duty(duty_w), .pwm_out(pwm_out)
  );

  assign duty = duty_w;
endmodule

// File: tb/sim_trim_regulator.sv
module sim_trim_regulator;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, run = 1'b0, ref_type = 1'b0, dual_cfg = 1'b0, alt_sel = 1'b0;
  logic mfg_mode = 1'b0, mrg_hi = 1'b0, mrg_lo = 1'b0;
  logic [11:0] tgt_nom = 12'd2000, tgt_alt = 12'd1800, tgt_hi = 12'd2400, tgt_lo = 12'd1200;
  logic [11:0] deadband = 12'd3;
  logic [9:0]  init_duty = 10'd300;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = 12'd0;
  logic        pwm_out, conv_en, settled, learn_fail, pol_up;
  logic [9:0]  duty;

  trim_regulator #(.PRE_DIV(1)) u0 (
    .clk(clk), .rst(rst), .run(run), .ref_type(ref_type), .dual_cfg(dual_cfg),
    .alt_sel(alt_sel), .mfg_mode(mfg_mode), .mrg_hi(mrg_hi), .mrg_lo(mrg_lo),
    .tgt_nom(tgt_nom), .tgt_alt(tgt_alt), .tgt_hi(tgt_hi), .tgt_lo(tgt_lo),
    .deadband(deadband), .init_duty(init_duty), .smp_valid(smp_valid),
    .smp_data(smp_data), .pwm_out(pwm_out), .conv_en(conv_en), .duty(duty),
    .settled(settled), .learn_fail(learn_fail), .pol_up(pol_up)
  );

  integer errs = 0, checks = 0;
  bit done = 0, started = 0;

  task automatic chk(input string req, input integer act, input integer exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // plant: reading = offset + sign*2*duty, clamped to 12 bits
  integer p_off = 1000, p_sgn = 1, gap_cnt = 0;
  function automatic integer plant(input integer d);
    integer v;
    v = (p_sgn == 0) ? 1500 : p_off + p_sgn * 2 * d;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  always @(negedge clk) begin
    if (gap_cnt == 3) begin
      gap_cnt = 0;
      smp_valid <= 1'b1;
      smp_data  <= 12'(plant(duty));
    end else begin
      gap_cnt = gap_cnt + 1;
      smp_valid <= 1'b0;
    end
  end

  // behavioural reference model
  integer m_st = 0, m_duty = 0, m_d0 = 0, m_nud = 0, m_base = 0, m_try = 0, m_pc = 0;
  integer m_en = 0, m_set = 0, m_fail = 0, m_pol = 0, m_dir = 0;

  function automatic integer clampd(input integer v);
    return (v < 0) ? 0 : (v > 1023) ? 1023 : v;
  endfunction

  function automatic integer cur_tgt();
    if (mfg_mode && mrg_hi) return tgt_hi;
    if (mfg_mode && mrg_lo) return tgt_lo;
    if (alt_sel && dual_cfg) return tgt_alt;
    return tgt_nom;
  endfunction

  always @(posedge clk) begin
    integer e, df, db;
    started = 1;
    db = deadband;
    if (rst) begin
      m_st = 0; m_duty = init_duty; m_en = 0; m_set = 0; m_fail = 0; m_pol = 0;
    end else if (!run) begin
      m_st = 0; m_duty = init_duty; m_en = 0; m_set = 0; m_fail = 0;
    end else begin
      case (m_st)
        0: if (ref_type) begin m_duty = 1023; m_pc = 0; m_st = 1; end
           else begin m_en = 1; m_nud = 4; m_try = 0; m_st = 2; end
        1: if (smp_valid) begin
             if (m_pc == 3) begin m_en = 1; m_pol = 1; m_st = 4; end
             else m_pc = m_pc + 1;
           end
        2: if (smp_valid) begin
             m_base = smp_data; m_d0 = m_duty; m_dir = (m_duty < 512);
             m_duty = clampd(m_dir ? m_duty + m_nud : m_duty - m_nud);
             m_st = 3;
           end
        3: if (smp_valid) begin
             df = smp_data - m_base;
             if (df > db || df < -db) begin m_pol = ((df > 0) == (m_dir != 0)); m_st = 4; end
             else begin
               m_duty = m_d0;
               if (m_try == 2) begin m_fail = 1; m_st = 5; end
               else begin m_try = m_try + 1; m_nud = m_nud * 2; m_st = 2; end
             end
           end
        4: if (smp_valid) begin
             e = cur_tgt() - smp_data;
             if (e > db) begin m_duty = clampd(m_pol ? m_duty + 1 : m_duty - 1); m_set = 0; end
             else if (e < -db) begin m_duty = clampd(m_pol ? m_duty - 1 : m_duty + 1); m_set = 0; end
             else m_set = 1;
           end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5 duty vs model", duty, m_duty);
      chk("R7 settled vs model", settled, m_set);
      chk("R4 learn_fail vs model", learn_fail, m_fail);
      chk("R8 conv_en vs model", conv_en, m_en);
      chk("R3 pol_up vs model", pol_up, m_pol);
    end
  end

  task automatic wait_n(input integer n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pwm(input integer exp, input string req);
    integer hi = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(req, hi, exp);
  endtask

  task automatic restart();
    run = 1'b0;
    wait_n(4);
  endtask

  initial begin
    wait_n(4);
    // R10 reset state
    chk("R10 duty at reset", duty, 300);
    chk("R10 conv_en at reset", conv_en, 0);
    chk("R10 pwm at reset", pwm_out, 0);
    chk("R10 pol_up at reset", pol_up, 0);
    rst = 1'b0;
    // R1 / R9 PWM while idle
    wait_n(2100);
    chk("R9 duty follows init_duty", duty, 300);
    count_pwm(300, "R1 high steps for duty 300");
    init_duty = 10'd0;
    wait_n(2100);
    count_pwm(0, "R1 duty zero low");
    init_duty = 10'd1023;
    wait_n(2100);
    count_pwm(1023, "R1 high steps for duty 1023");

    // R3 R5 R7 normal polarity
    init_duty = 10'd300; wait_n(4);
    run = 1'b1;
    wait_n(1500);
    chk("R3 pol_up learned positive", pol_up, 1);
    chk("R5 duty settles nominal", duty, 499);
    chk("R7 settled high", settled, 1);

    // R2 target select
    alt_sel = 1'b1; wait_n(200);
    chk("R2 alt ignored without dual_cfg", duty, 499);
    dual_cfg = 1'b1; wait_n(1000);
    chk("R2 alternate target", duty, 401);
    mrg_hi = 1'b1; wait_n(200);
    chk("R2 margin ignored without mfg_mode", duty, 401);
    mfg_mode = 1'b1; mrg_lo = 1'b1; wait_n(3000);
    chk("R2 margin high wins over low", duty, 699);
    mrg_hi = 1'b0; wait_n(3000);
    chk("R2 margin low target", duty, 101);
    chk("R7 settled at margin low", settled, 1);
    mfg_mode = 1'b0; mrg_lo = 1'b0; alt_sel = 1'b0; dual_cfg = 1'b0;

    // R9 run low
    restart();
    chk("R9 conv_en low when stopped", conv_en, 0);
    chk("R9 settled low when stopped", settled, 0);

    // R3 inverted polarity
    p_sgn = -1; p_off = 3000; init_duty = 10'd700; wait_n(4);
    run = 1'b1; wait_n(1500);
    chk("R3 pol_up learned negative", pol_up, 0);
    chk("R5 duty settles inverted", duty, 501);

    // R6 saturation high and low
    restart();
    p_sgn = 1; p_off = 1000; tgt_nom = 12'd4000; init_duty = 10'd1000; wait_n(4);
    run = 1'b1; wait_n(400);
    chk("R6 saturate at 1023", duty, 1023);
    chk("R7 not settled at rail", settled, 0);
    restart();
    tgt_nom = 12'd0; init_duty = 10'd20; wait_n(4);
    run = 1'b1; wait_n(300);
    chk("R6 saturate at 0", duty, 0);

    // R4 learn failure
    restart();
    p_sgn = 0; tgt_nom = 12'd2000; init_duty = 10'd300; wait_n(4);
    run = 1'b1; wait_n(200);
    chk("R4 learn_fail raised", learn_fail, 1);
    chk("R4 duty restored", duty, 300);

    // R8 precharge path
    restart();
    p_sgn = 1; ref_type = 1'b1; wait_n(4);
    run = 1'b1; wait_n(1);
    chk("R8 duty full during precharge", duty, 1023);
    chk("R8 enable held low", conv_en, 0);
    wait_n(2600);
    chk("R8 enable after precharge", conv_en, 1);
    chk("R8 duty decremented to target", duty, 501);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule